// File: doc/BRIEF.md
# Data Lane Training Pattern Engine

This block produces and recognises the training sequence of a 16-bit source-synchronous data bus. Besides the data lanes, the bus carries a control line, a parity line and a protocol line. The sequencer advances by one phase on each tick of a phase-rate clock. In that model every clock edge of the real interface is one phase.

On the transmit side, a one-cycle start request launches the sequence and a programmable repeat count (alpha) sets its length. In SPI-4 style mode the sequence opens with one idle control word, and its low nibble carries a caller-supplied 4-bit check code. In CSIX style mode the idle word is skipped. Each repeat holds the bus at one fixed word for ten phases and then at its complement for ten phases. The parity and protocol lines are driven as well. While no sequence is running, user traffic passes straight through to the bus.

On the receive side, a detector watches the sampled bus. When the training start pattern has persisted long enough, it raises a one-cycle deskew-start pulse. An ignore-training input suppresses that pulse.

Top module: `lane_train_engine`

## Requirements
- R1: While no sequence is active (busy low), tx_data_o, tx_ctl_o, tx_par_o and tx_prot_o equal usr_data_i, usr_ctl_i, usr_par_i and usr_prot_i.
- R2: In SPI-4 mode (spi_mode_i=1), the first phase after an accepted start is an idle control word: tx_ctl_o=1, tx_prot_o=0, tx_par_o=0 and tx_data_o = {12'h000, idle_code_i captured with the start}.
- R3: Each repeat is 10 phases of tx_ctl_o=1, tx_data_o=16'h0FFF, tx_par_o=1, tx_prot_o=0, followed by 10 phases of tx_ctl_o=0, tx_data_o=16'hF000, tx_par_o=0, tx_prot_o=1.
- R4: The repeat is issued alpha times, using the alpha_i value captured with the start. busy_o is high for exactly 20*alpha+1 phases in SPI-4 mode and 20*alpha phases in CSIX mode, beginning in the cycle after the start is sampled.
- R5: In CSIX mode (spi_mode_i=0) no idle word is sent, and the first phase is the first high-half phase of R3.
- R6: done_o pulses high for exactly one cycle, in the cycle after the last phase. With alpha=0, SPI-4 mode sends only the idle word. With alpha=0, CSIX mode raises done_o in the cycle after the start and never raises busy_o.
- R7: A start request while busy_o is high is ignored. The running sequence keeps its length and pattern even if alpha_i changes.
- R8: deskew_start_o pulses for one cycle in the cycle after the third consecutive rx sample with rx_ctl_i=1 and rx_data_i=16'h0FFF.
- R9: No pulse is produced when ignore_train_i is 1 on the sample that completes the three-sample run.
- R10: Any sample that does not match clears the match count. deskew_start_o fires at most once per unbroken run of matches.
- R11: After reset, busy_o, done_o and deskew_start_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to send a training sequence |
| spi_mode_i | input | 1 | 1: SPI-4 style with idle word; 0: CSIX style |
| alpha_i | input | ALPHA_W | Repeat count |
| idle_code_i | input | 4 | Check code placed in the idle word's low nibble |
| usr_data_i | input | 16 | User data passed through when idle |
| usr_ctl_i | input | 1 | User control line |
| usr_par_i | input | 1 | User parity line |
| usr_prot_i | input | 1 | User protocol line |
| tx_data_o | output | 16 | Transmit data lanes |
| tx_ctl_o | output | 1 | Transmit control line |
| tx_par_o | output | 1 | Transmit parity line |
| tx_prot_o | output | 1 | Transmit protocol line |
| busy_o | output | 1 | Training sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| rx_data_i | input | 16 | Sampled receive data lanes |
| rx_ctl_i | input | 1 | Sampled receive control line |
| ignore_train_i | input | 1 | Suppress deskew-start |
| deskew_start_o | output | 1 | One-cycle pulse on recognised training start |

## Verification
The hardest case to reach is a second start request arriving mid-sequence, together with a different alpha. The stimulus places it in the low half of a middle repeat, then checks every phase up to the original end and the single done pulse. The detector's once-per-run rule is also hard to cover. The stimulus holds the match pattern well past three samples, breaks runs with a single flipped data bit and with a dropped control line, and raises ignore exactly on a completing sample so that the saturated count blocks any late pulse.

// File: rtl/train_pkg.sv
package train_pkg;
  localparam int LANE_W   = 16;
  localparam int HALF_LEN = 10;
  localparam logic [LANE_W-1:0] WORD_HI = 16'h0FFF;
  localparam logic [LANE_W-1:0] WORD_LO = 16'hF000;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_IDLE = 2'd1,
    ST_HI   = 2'd2,
    ST_LO   = 2'd3
  } tr_state_e;
endpackage

// File: rtl/train_seq.sv
module train_seq
  import train_pkg::*;
#(
  parameter int ALPHA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               spi_mode_i,
  input  logic [ALPHA_W-1:0] alpha_i,
  input  logic [3:0]         idle_code_i,
  output tr_state_e          state_o,
  output logic [3:0]         code_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int PH_W = $clog2(HALF_LEN);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_LEN - 1);

  tr_state_e          st_q, st_n;
  logic [PH_W-1:0]    ph_q, ph_n;
  logic [ALPHA_W-1:0] rep_q, rep_n;
  logic [ALPHA_W-1:0] alpha_q, alpha_n;
  logic [3:0]         code_q, code_n;
  logic               done_q, done_n;
  logic               adv_en;

  assign adv_en = (st_q != ST_OFF) || start_i;

  always_comb begin
    st_n    = st_q;
    ph_n    = ph_q;
    rep_n   = rep_q;
    alpha_n = alpha_q;
    code_n  = code_q;
    done_n  = 1'b0;
    unique case (st_q)
      ST_OFF: begin
        if (start_i) begin
          alpha_n = alpha_i;
          code_n  = idle_code_i;
          ph_n    = '0;
          if (spi_mode_i) begin
            st_n = ST_IDLE;
          end else if (alpha_i != '0) begin
            st_n  = ST_HI;
            rep_n = alpha_i - ALPHA_W'(1);
          end else begin
            done_n = 1'b1;
          end
        end
      end
      ST_IDLE: begin
        ph_n = '0;
        if (alpha_q != '0) begin
          st_n  = ST_HI;
          rep_n = alpha_q - ALPHA_W'(1);
        end else begin
          st_n   = ST_OFF;
          done_n = 1'b1;
        end
      end
      ST_HI: begin
        if (ph_q == PH_LAST) begin
          st_n = ST_LO;
          ph_n = '0;
        end else begin
          ph_n = ph_q + PH_W'(1);
        end
      end
      ST_LO: begin
        if (ph_q == PH_LAST) begin
          ph_n = '0;
          if (rep_q == '0) begin
            st_n   = ST_OFF;
            done_n = 1'b1;
          end else begin
            st_n  = ST_HI;
            rep_n = rep_q - ALPHA_W'(1);
          end
        end else begin
          ph_n = ph_q + PH_W'(1);
        end
      end
      default: st_n = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OFF;
      ph_q    <= '0;
      rep_q   <= '0;
      alpha_q <= '0;
      code_q  <= '0;
    end else if (adv_en) begin
      st_q    <= st_n;
      ph_q    <= ph_n;
      rep_q   <= rep_n;
      alpha_q <= alpha_n;
      code_q  <= code_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_n;
  end

  assign state_o = st_q;
  assign code_o  = code_q;
  assign busy_o  = (st_q != ST_OFF);
  assign done_o  = done_q;

  // A high half runs its full length whatever start_i does (R3, R7)
  p_hi_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HI && ph_q != PH_LAST) |=> (st_q == ST_HI));

  p_lo_after_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HI && ph_q == PH_LAST) |=> (st_q == ST_LO));

  p_alpha_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_OFF) |=> $stable(alpha_q));

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st_q == ST_OFF));
endmodule

// File: rtl/train_gen.sv
module train_gen
  import train_pkg::*;
(
  input  tr_state_e         state_i,
  input  logic [3:0]        code_i,
  input  logic [LANE_W-1:0] usr_data_i,
  input  logic              usr_ctl_i,
  input  logic              usr_par_i,
  input  logic              usr_prot_i,
  output logic [LANE_W-1:0] tx_data_o,
  output logic              tx_ctl_o,
  output logic              tx_par_o,
  output logic              tx_prot_o
);
  always_comb begin
    unique case (state_i)
      ST_IDLE: begin
        tx_data_o = {{(LANE_W-4){1'b0}}, code_i};
        tx_ctl_o  = 1'b1;
        tx_par_o  = 1'b0;
        tx_prot_o = 1'b0;
      end
      ST_HI: begin
        tx_data_o = WORD_HI;
        tx_ctl_o  = 1'b1;
        tx_par_o  = 1'b1;
        tx_prot_o = 1'b0;
      end
      ST_LO: begin
        tx_data_o = WORD_LO;
        tx_ctl_o  = 1'b0;
        tx_par_o  = 1'b0;
        tx_prot_o = 1'b1;
      end
      default: begin
        tx_data_o = usr_data_i;
        tx_ctl_o  = usr_ctl_i;
        tx_par_o  = usr_par_i;
        tx_prot_o = usr_prot_i;
      end
    endcase
  end
endmodule

// File: rtl/train_detect.sv
module train_detect
  import train_pkg::*;
#(
  parameter int MATCH_RUN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] rx_data_i,
  input  logic              rx_ctl_i,
  input  logic              ignore_i,
  output logic              fire_o
);
  localparam int CNT_W = $clog2(MATCH_RUN + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MATCH_RUN);
  localparam logic [CNT_W-1:0] CNT_ARM  = CNT_W'(MATCH_RUN - 1);

  logic             match;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             fire_q, fire_n;

  assign match = rx_ctl_i && (rx_data_i == WORD_HI);

  always_comb begin
    if (!match)                cnt_n = '0;
    else if (cnt_q != CNT_FULL) cnt_n = cnt_q + CNT_W'(1);
    else                        cnt_n = cnt_q;
    fire_n = match && (cnt_q == CNT_ARM) && !ignore_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      fire_q <= fire_n;
    end
  end

  assign fire_o = fire_q;

  p_fire_on_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> $past(match));

  p_fire_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> !$past(ignore_i));

  p_fire_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> !fire_q);
endmodule

// File: rtl/lane_train_engine.sv
module lane_train_engine
  import train_pkg::*;
#(
  parameter int ALPHA_W   = 8,
  parameter int MATCH_RUN = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               spi_mode_i,
  input  logic [ALPHA_W-1:0] alpha_i,
  input  logic [3:0]         idle_code_i,
  input  logic [15:0]        usr_data_i,
  input  logic               usr_ctl_i,
  input  logic               usr_par_i,
  input  logic               usr_prot_i,
  output logic [15:0]        tx_data_o,
  output logic               tx_ctl_o,
  output logic               tx_par_o,
  output logic               tx_prot_o,
  output logic               busy_o,
  output logic               done_o,
  input  logic [15:0]        rx_data_i,
  input  logic               rx_ctl_i,
  input  logic               ignore_train_i,
  output logic               deskew_start_o
);
  tr_state_e  seq_state;
  logic [3:0] seq_code;

  train_seq #(.ALPHA_W(ALPHA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .spi_mode_i  (spi_mode_i),
    .alpha_i     (alpha_i),
    .idle_code_i (idle_code_i),
    .state_o     (seq_state),
    .code_o      (seq_code),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  train_gen u_gen (
    .state_i    (seq_state),
    .code_i     (seq_code),
    .usr_data_i (usr_data_i),
    .usr_ctl_i  (usr_ctl_i),
    .usr_par_i  (usr_par_i),
    .usr_prot_i (usr_prot_i),
    .tx_data_o  (tx_data_o),
    .tx_ctl_o   (tx_ctl_o),
    .tx_par_o   (tx_par_o),
    .tx_prot_o  (tx_prot_o)
  );

  train_detect #(.MATCH_RUN(MATCH_RUN)) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_data_i (rx_data_i),
    .rx_ctl_i  (rx_ctl_i),
    .ignore_i  (ignore_train_i),
    .fire_o    (deskew_start_o)
  );

  // done and busy never overlap (R6)
  p_done_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

// File: tb/tb_lane_train_engine.sv
module tb_lane_train_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, spi_mode_i;
  logic [7:0]  alpha_i;
  logic [3:0]  idle_code_i;
  logic [15:0] usr_data_i, rx_data_i, tx_data_o;
  logic        usr_ctl_i, usr_par_i, usr_prot_i;
  logic        tx_ctl_o, tx_par_o, tx_prot_o, busy_o, done_o;
  logic        rx_ctl_i, ignore_train_i, deskew_start_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lane_train_engine dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .spi_mode_i(spi_mode_i),
    .alpha_i(alpha_i), .idle_code_i(idle_code_i), .usr_data_i(usr_data_i),
    .usr_ctl_i(usr_ctl_i), .usr_par_i(usr_par_i), .usr_prot_i(usr_prot_i),
    .tx_data_o(tx_data_o), .tx_ctl_o(tx_ctl_o), .tx_par_o(tx_par_o),
    .tx_prot_o(tx_prot_o), .busy_o(busy_o), .done_o(done_o),
    .rx_data_i(rx_data_i), .rx_ctl_i(rx_ctl_i),
    .ignore_train_i(ignore_train_i), .deskew_start_o(deskew_start_o)
  );

  // {expected pulse after this sample, ignore, ctl, data}
  localparam int NV = 17;
  localparam logic [18:0] RXV [NV] = '{
    {1'b0, 1'b0, 1'b1, 16'h0FFF},
    {1'b0, 1'b0, 1'b1, 16'h0FFF},
    {1'b1, 1'b0, 1'b1, 16'h0FFF},
    {1'b0, 1'b0, 1'b1, 16'h0FFF},
    {1'b0, 1'b0, 1'b1, 16'h0FFF},
    {1'b0, 1'b0, 1'b0, 16'h0FFF},
    {1'b0, 1'b0, 1'b1, 16'h0FFF},
    {1'b0, 1'b0, 1'b1, 16'h0FFF},
    {1'b0, 1'b0, 1'b1, 16'h0FFE},
    {1'b0, 1'b0, 1'b1, 16'h0FFF},
    {1'b0, 1'b0, 1'b1, 16'h0FFF},
    {1'b0, 1'b1, 1'b1, 16'h0FFF},
    {1'b0, 1'b0, 1'b1, 16'h0FFF},
    {1'b0, 1'b0, 1'b1, 16'hF000},
    {1'b0, 1'b0, 1'b1, 16'h0FFF},
    {1'b0, 1'b0, 1'b1, 16'h0FFF},
    {1'b1, 1'b0, 1'b1, 16'h0FFF}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [18:0] tx_bus();
    return {tx_ctl_o, tx_par_o, tx_prot_o, tx_data_o};
  endfunction

  function automatic logic [18:0] usr_bus();
    return {usr_ctl_i, usr_par_i, usr_prot_i, usr_data_i};
  endfunction

  function automatic logic [18:0] exp_phase(input bit spi, input int j,
                                            input logic [3:0] code);
    int k;
    if (spi && j == 0) return {3'b100, 12'h000, code};
    k = spi ? j - 1 : j;
    if ((k % 20) < 10) return {3'b110, 16'h0FFF};
    return {3'b001, 16'hF000};
  endfunction

  task automatic run_train(input bit spi, input int alpha, input logic [3:0] code,
                           input int inject_at);
    int total;
    total = spi ? 20 * alpha + 1 : 20 * alpha;
    @(negedge clk);
    start_i = 1'b1; spi_mode_i = spi; alpha_i = 8'(alpha); idle_code_i = code;
    for (int j = 0; j <= total; j++) begin
      @(negedge clk);
      if (j == total) begin
        check(done_o == 1'b1, "R6 done pulse", 32'(done_o), 1);
        check(busy_o == 1'b0, "R4 busy ends", 32'(busy_o), 0);
        check(tx_bus() == usr_bus(), "R1 passthrough at done", 32'(tx_bus()),
              32'(usr_bus()));
      end else begin
        check(busy_o == 1'b1 && done_o == 1'b0, "R4 busy during phase",
              32'({busy_o, done_o}), 32'h2);
        check(tx_bus() == exp_phase(spi, j, code),
              spi ? "R2 R3 SPI-4 phase" : "R3 R5 CSIX phase",
              32'(tx_bus()), 32'(exp_phase(spi, j, code)));
      end
      start_i = 1'b0;
      idle_code_i = ~code;
      if (j == inject_at) begin
        start_i = 1'b1;
        alpha_i = 8'd1;
        spi_mode_i = ~spi;
      end
    end
    @(negedge clk);
    check(done_o == 1'b0 && busy_o == 1'b0, "R6 single done", 32'({busy_o, done_o}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start_i = 0; spi_mode_i = 1; alpha_i = 0; idle_code_i = 0;
    usr_data_i = 16'hA5C3; usr_ctl_i = 0; usr_par_i = 1; usr_prot_i = 1;
    rx_data_i = 16'h0000; rx_ctl_i = 0; ignore_train_i = 0;
    repeat (3) @(negedge clk);
    check({busy_o, done_o, deskew_start_o} == 3'b000, "R11 reset outputs",
          32'({busy_o, done_o, deskew_start_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_bus() == usr_bus(), "R1 passthrough idle", 32'(tx_bus()), 32'(usr_bus()));
    usr_data_i = 16'h1234; usr_ctl_i = 1; usr_par_i = 0; usr_prot_i = 0;
    @(negedge clk);
    check(tx_bus() == usr_bus(), "R1 passthrough new value", 32'(tx_bus()),
          32'(usr_bus()));

    // detector vector table (R8 R9 R10)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0)
        check(deskew_start_o == RXV[i-1][18], "R8 R9 R10 detector",
              32'(deskew_start_o), 32'(RXV[i-1][18]));
      ignore_train_i = RXV[i][17];
      rx_ctl_i       = RXV[i][16];
      rx_data_i      = RXV[i][15:0];
    end
    @(negedge clk);
    check(deskew_start_o == RXV[NV-1][18], "R8 detector last", 32'(deskew_start_o),
          32'(RXV[NV-1][18]));
    rx_ctl_i = 0; ignore_train_i = 0;
    @(negedge clk);
    check(deskew_start_o == 1'b0, "R10 no repeat pulse", 32'(deskew_start_o), 0);

    // transmit runs
    run_train(1'b1, 2, 4'hA, -1);
    run_train(1'b0, 1, 4'h5, -1);
    run_train(1'b1, 0, 4'h6, -1);
    run_train(1'b0, 0, 4'h3, -1);
    run_train(1'b1, 3, 4'h9, 35);   // R7 start mid-sequence ignored
    run_train(1'b0, 2, 4'hC, 12);   // R7 in CSIX mode

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule